// File: doc/BRIEF.md
# Tournament Next-PC Predictor

This block sits beside the fetch stage and guesses the address to fetch next. Two direction predictors run side by side. One uses a global record of recent branch outcomes. The other uses a per-address record of that branch's own outcomes. A chooser table, indexed by fetch address, picks which of the two is used for each branch. When the chosen direction is taken, the next fetch address comes from a target table indexed by fetch address. Otherwise fetch moves on to the next sequential word.

The fetch stage copies the prediction fields that leave the block (direction, both component votes, next PC and global-history snapshot) into the instruction and carries them down the pipe. When the branch resolves in execute, execute returns those fields together with the real outcome and the real next PC. The block uses them to train its tables. It also owns an epoch counter that fetch stamps on every instruction. A resolved misprediction advances the epoch and asks fetch to redirect. An update that carries an out-of-date epoch belongs to a squashed wrong-path instruction, so it is flagged and ignored.

Top module: `nextpc_tournament_pred`

## Requirements
- R1: After reset every counter table entry holds 1 (weakly not-taken, chooser weakly favouring local), all local histories, the global history, the targets and the epoch are 0. Every fetch therefore predicts not-taken with next PC = fetch PC + 4, and `p_use_glob` is 0.
- R2: `p_glob` is bit 1 of the global 2-bit counter indexed by the 6-bit global history, which is also presented on `p_ghist`. An accepted update trains the global counter at index `u_ghist`. It shifts the actual outcome into bit 0 of the global history, and the older bits move up one place.
- R3: Fetch PC bits [7:2] select a 6-bit local history. That history indexes a second table of 2-bit counters, and `p_loc` is bit 1 of the selected counter. An accepted update trains the counter indexed by the current history of `u_pc[7:2]`, then shifts the outcome into bit 0 of that history.
- R4: The chooser counter at fetch PC[7:2] selects the global vote when its bit 1 is 1 and the local vote when it is 0. It is trained only when `u_pred_glob` differs from `u_pred_loc`: it counts up if the global vote matched the outcome, and down otherwise.
- R5: Every 2-bit counter counts up on a taken outcome and down on a not-taken outcome, and saturates at 0 and 3. `p_taken` is the vote that the chooser selects.
- R6: When `p_taken` is 1, `p_next_pc` is the target-table entry at fetch PC[7:2]. When it is 0, `p_next_pc` is fetch PC + 4. An accepted taken update writes `u_next_pc` into the target entry at `u_pc[7:2]`. A not-taken update leaves the target entry unchanged.
- R7: An accepted update is a misprediction when its actual direction differs from `u_pred_taken`, or when it is taken and `u_next_pc` differs from `u_pred_next`. In that cycle `u_redirect` is 1, and the epoch then advances by one, modulo 4.
- R8: An update whose `u_epoch` differs from the current epoch raises `u_stale`. It changes no table, history or epoch, and `u_redirect` stays 0.
- R9: A cycle with `u_valid` low changes no state, and the epoch holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_pc | input | 32 | Address being fetched |
| p_taken | output | 1 | Predicted direction |
| p_next_pc | output | 32 | Predicted next fetch address |
| p_glob | output | 1 | Global component vote |
| p_loc | output | 1 | Local component vote |
| p_use_glob | output | 1 | Chooser picked the global vote |
| p_ghist | output | 6 | Global history used for this prediction |
| f_epoch | output | 2 | Current epoch for tagging fetched instructions |
| u_valid | input | 1 | Resolved branch update present |
| u_pc | input | 32 | Address of the resolved branch |
| u_epoch | input | 2 | Epoch tag carried by the resolved branch |
| u_taken | input | 1 | Actual direction |
| u_next_pc | input | 32 | Actual next PC |
| u_pred_taken | input | 1 | Direction predicted at fetch |
| u_pred_next | input | 32 | Next PC predicted at fetch |
| u_pred_glob | input | 1 | Global vote at fetch |
| u_pred_loc | input | 1 | Local vote at fetch |
| u_ghist | input | 6 | Global history snapshot taken at fetch |
| u_stale | output | 1 | Update carries an out-of-date epoch |
| u_redirect | output | 1 | Accepted update mispredicted; refetch from `u_next_pc` |

## Verification
The branches in the random stimulus lean toward a fixed direction according to their address, and a small fraction flip. This builds up saturated counters, aliasing local histories and real component disagreements, which exercise the chooser. Half of the updates carry the prediction fields the block actually produced, as a real pipeline would. The other half carry arbitrary fields, which separates the misprediction logic from the training logic. About one update in eight carries a stale epoch and some cycles carry no update, so these show whether anything leaks through the guard. Directed runs cover the reset state, saturation at both ends under a long run of one direction, and a target change on an already-taken branch, where the direction is correct but the target is wrong.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_TOP = 2'd3;
  localparam ctr2_t CTR_BOT = 2'd0;

  // saturating two-bit step
  function automatic ctr2_t ctr_step(ctr2_t c, logic up);
    ctr2_t r;
    if (up) r = (c == CTR_TOP) ? c : c + 2'd1;
    else    r = (c == CTR_BOT) ? c : c - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/bp_ctr_bank.sv
module bp_ctr_bank
  import bp_pkg::*;
#(
  parameter int    IDX_W   = 6,
  parameter ctr2_t RST_VAL = 2'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t tbl [DEPTH];
  ctr2_t wr_nxt;

  always_comb wr_nxt = ctr_step(tbl[wr_idx], wr_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= RST_VAL;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_nxt;
    end
  end

  assign rd_ctr = tbl[rd_idx];

  // R5: a full counter stays full on another taken outcome
  a_r5_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && tbl[wr_idx] == CTR_TOP) |=> tbl[$past(wr_idx)] == CTR_TOP);
  // R5: an empty counter stays empty on another not-taken outcome
  a_r5_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && tbl[wr_idx] == CTR_BOT) |=> tbl[$past(wr_idx)] == CTR_BOT);
endmodule

// File: rtl/bp_hist_bank.sv
module bp_hist_bank #(
  parameter int IDX_W = 6,
  parameter int HIS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] fa_idx,
  output logic [HIS_W-1:0] fa_hist,
  input  logic [IDX_W-1:0] ua_idx,
  output logic [HIS_W-1:0] ua_hist,
  input  logic             wr_en,
  input  logic             wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIS_W-1:0] tbl [DEPTH];
  logic [HIS_W-1:0] wr_nxt;

  always_comb wr_nxt = {tbl[ua_idx][HIS_W-2:0], wr_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[ua_idx] <= wr_nxt;
    end
  end

  assign fa_hist = tbl[fa_idx];
  assign ua_hist = tbl[ua_idx];

  // R3: the newest outcome lands in bit 0, older bits move up
  a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tbl[$past(ua_idx)][0] == $past(wr_bit)) &&
              (tbl[$past(ua_idx)][HIS_W-1:1] == $past(ua_hist[HIS_W-2:0])));
endmodule

// File: rtl/bp_tgt_bank.sv
module bp_tgt_bank #(
  parameter int IDX_W = 6,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_tgt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_tgt
);
  localparam int DEPTH = 1 << IDX_W;

  logic [PC_W-1:0] tbl [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_tgt;
    end
  end

  assign rd_tgt = tbl[rd_idx];

  // R6: a written target is readable on the next cycle
  a_r6_target_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl[$past(wr_idx)] == $past(wr_tgt));
endmodule

// File: rtl/nextpc_tournament_pred.sv
module nextpc_tournament_pred
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int LH_W  = 6,
  parameter int GH_W  = 6,
  parameter int EP_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] f_pc,
  output logic            p_taken,
  output logic [PC_W-1:0] p_next_pc,
  output logic            p_glob,
  output logic            p_loc,
  output logic            p_use_glob,
  output logic [GH_W-1:0] p_ghist,
  output logic [EP_W-1:0] f_epoch,
  input  logic            u_valid,
  input  logic [PC_W-1:0] u_pc,
  input  logic [EP_W-1:0] u_epoch,
  input  logic            u_taken,
  input  logic [PC_W-1:0] u_next_pc,
  input  logic            u_pred_taken,
  input  logic [PC_W-1:0] u_pred_next,
  input  logic            u_pred_glob,
  input  logic            u_pred_loc,
  input  logic [GH_W-1:0] u_ghist,
  output logic            u_stale,
  output logic            u_redirect
);
  localparam int          IDX_LO = 2;
  localparam int          IDX_HI = IDX_LO + IDX_W - 1;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  // ---------------- state registers ----------------
  logic [GH_W-1:0] ghr_q, ghr_d;
  logic [EP_W-1:0] ep_q, ep_d;
  logic            ghr_en, ep_en;

  // ---------------- index extraction ----------------
  logic [IDX_W-1:0] f_idx, u_idx;
  assign f_idx = f_pc[IDX_HI:IDX_LO];
  assign u_idx = u_pc[IDX_HI:IDX_LO];

  // ---------------- update qualification ----------------
  logic accept, dir_wrong, tgt_wrong, mispred;
  always_comb begin
    u_stale   = u_valid && (u_epoch != ep_q);
    accept    = u_valid && (u_epoch == ep_q);
    dir_wrong = u_taken != u_pred_taken;
    tgt_wrong = u_taken && (u_next_pc != u_pred_next);
    mispred   = accept && (dir_wrong || tgt_wrong);
  end
  assign u_redirect = mispred;

  // ---------------- next-state for history and epoch ----------------
  always_comb begin
    ghr_en = accept;
    ghr_d  = {ghr_q[GH_W-2:0], u_taken};
    ep_en  = mispred;
    ep_d   = ep_q + EP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ghr_q <= '0;
    else if (ghr_en) ghr_q <= ghr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ep_q <= '0;
    else if (ep_en) ep_q <= ep_d;
  end

  // ---------------- global component ----------------
  ctr2_t g_ctr;
  bp_ctr_bank #(.IDX_W(GH_W), .RST_VAL(2'd1)) u_glob (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghr_q), .rd_ctr(g_ctr),
    .wr_en(accept), .wr_idx(u_ghist), .wr_up(u_taken)
  );

  // ---------------- local component ----------------
  logic [LH_W-1:0] f_lhist, u_lhist;
  bp_hist_bank #(.IDX_W(IDX_W), .HIS_W(LH_W)) u_lhist_bank (
    .clk(clk), .rst_n(rst_n),
    .fa_idx(f_idx), .fa_hist(f_lhist),
    .ua_idx(u_idx), .ua_hist(u_lhist),
    .wr_en(accept), .wr_bit(u_taken)
  );

  ctr2_t l_ctr;
  bp_ctr_bank #(.IDX_W(LH_W), .RST_VAL(2'd1)) u_loc (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(f_lhist), .rd_ctr(l_ctr),
    .wr_en(accept), .wr_idx(u_lhist), .wr_up(u_taken)
  );

  // ---------------- chooser ----------------
  ctr2_t c_ctr;
  logic  ch_en, ch_up;
  always_comb begin
    ch_en = accept && (u_pred_glob != u_pred_loc);
    ch_up = (u_pred_glob == u_taken);
  end

  bp_ctr_bank #(.IDX_W(IDX_W), .RST_VAL(2'd1)) u_choose (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(f_idx), .rd_ctr(c_ctr),
    .wr_en(ch_en), .wr_idx(u_idx), .wr_up(ch_up)
  );

  // ---------------- target table ----------------
  logic [PC_W-1:0] tgt;
  bp_tgt_bank #(.IDX_W(IDX_W), .PC_W(PC_W)) u_tgt (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(f_idx), .rd_tgt(tgt),
    .wr_en(accept && u_taken), .wr_idx(u_idx), .wr_tgt(u_next_pc)
  );

  // ---------------- prediction ----------------
  always_comb begin
    p_glob     = g_ctr[1];
    p_loc      = l_ctr[1];
    p_use_glob = c_ctr[1];
    p_taken    = p_use_glob ? p_glob : p_loc;
    p_next_pc  = p_taken ? tgt : (f_pc + STEP);
  end
  assign p_ghist = ghr_q;
  assign f_epoch = ep_q;

  // R7: a redirect advances the epoch by exactly one
  a_r7_epoch_advance: assert property (@(posedge clk) disable iff (!rst_n)
    u_redirect |=> f_epoch == $past(f_epoch) + EP_W'(1));
  // R9: without a redirect the epoch holds
  a_r9_epoch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !u_redirect |=> $stable(f_epoch));
  // R8: a stale update never redirects and leaves the history alone
  a_r8_stale_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (u_stale || !u_valid) |-> !u_redirect);
  a_r8_stale_hist: assert property (@(posedge clk) disable iff (!rst_n)
    (u_stale || !u_valid) |=> $stable(p_ghist));
  // R2: accepted outcome enters the global history at bit 0
  a_r2_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (u_valid && !u_stale) |=> p_ghist[0] == $past(u_taken));
endmodule

// File: tb/nextpc_tournament_pred_test.sv
`timescale 1ns/1ps
module nextpc_tournament_pred_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] f_pc;
  logic        p_taken, p_glob, p_loc, p_use_glob;
  logic [31:0] p_next_pc;
  logic [5:0]  p_ghist;
  logic [1:0]  f_epoch;
  logic        u_valid, u_taken, u_pred_taken, u_pred_glob, u_pred_loc;
  logic [31:0] u_pc, u_next_pc, u_pred_next;
  logic [1:0]  u_epoch;
  logic [5:0]  u_ghist;
  logic        u_stale, u_redirect;

  always #4 clk = ~clk;  // 125 MHz

  nextpc_tournament_pred uut (
    .clk(clk), .rst_n(rst_n), .f_pc(f_pc),
    .p_taken(p_taken), .p_next_pc(p_next_pc), .p_glob(p_glob), .p_loc(p_loc),
    .p_use_glob(p_use_glob), .p_ghist(p_ghist), .f_epoch(f_epoch),
    .u_valid(u_valid), .u_pc(u_pc), .u_epoch(u_epoch), .u_taken(u_taken),
    .u_next_pc(u_next_pc), .u_pred_taken(u_pred_taken), .u_pred_next(u_pred_next),
    .u_pred_glob(u_pred_glob), .u_pred_loc(u_pred_loc), .u_ghist(u_ghist),
    .u_stale(u_stale), .u_redirect(u_redirect)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  logic [1:0]  m_g  [64];
  logic [1:0]  m_lc [64];
  logic [1:0]  m_ch [64];
  logic [5:0]  m_lh [64];
  logic [31:0] m_tg [64];
  logic [5:0]  m_ghr;
  logic [1:0]  m_ep;

  function automatic logic [1:0] sat(logic [1:0] c, logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin
      m_g[i] = 2'd1; m_lc[i] = 2'd1; m_ch[i] = 2'd1; m_lh[i] = '0; m_tg[i] = '0;
    end
    m_ghr = '0; m_ep = '0;
  endtask

  // model prediction for an address
  task automatic model_pred(input logic [31:0] pc, output logic t, output logic [31:0] n,
                            output logic g, output logic l, output logic c);
    logic [5:0] ix;
    ix = pc[7:2];
    g = m_g[m_ghr][1];
    l = m_lc[m_lh[ix]][1];
    c = m_ch[ix][1];
    t = c ? g : l;
    n = t ? m_tg[ix] : pc + 32'd4;
  endtask

  task automatic step(input logic [31:0] pc, input logic uv, input logic [31:0] upc,
                      input logic [1:0] uep, input logic ut, input logic [31:0] un,
                      input logic upt, input logic [31:0] upn, input logic upg,
                      input logic upl, input logic [5:0] ugh);
    logic et, eg, el, ec, stale, acc, mis;
    logic [31:0] en;
    logic [5:0] li;
    @(negedge clk);
    f_pc = pc; u_valid = uv; u_pc = upc; u_epoch = uep; u_taken = ut; u_next_pc = un;
    u_pred_taken = upt; u_pred_next = upn; u_pred_glob = upg; u_pred_loc = upl; u_ghist = ugh;
    #1;
    model_pred(pc, et, en, eg, el, ec);
    stale = uv && (uep != m_ep);
    acc   = uv && (uep == m_ep);
    mis   = acc && ((ut != upt) || (ut && un != upn));
    chk("R2 p_glob", 32'(p_glob), 32'(eg));
    chk("R2 p_ghist", 32'(p_ghist), 32'(m_ghr));
    chk("R3 p_loc", 32'(p_loc), 32'(el));
    chk("R4 p_use_glob", 32'(p_use_glob), 32'(ec));
    chk("R5 p_taken", 32'(p_taken), 32'(et));
    chk("R6 p_next_pc", p_next_pc, en);
    chk("R7 f_epoch", 32'(f_epoch), 32'(m_ep));
    chk("R7 u_redirect", 32'(u_redirect), 32'(mis));
    chk("R8 u_stale", 32'(u_stale), 32'(stale));
    @(posedge clk);
    if (acc) begin
      li = upc[7:2];
      m_g[ugh] = sat(m_g[ugh], ut);
      m_lc[m_lh[li]] = sat(m_lc[m_lh[li]], ut);
      m_lh[li] = {m_lh[li][4:0], ut};
      m_ghr = {m_ghr[4:0], ut};
      if (upg != upl) m_ch[li] = sat(m_ch[li], upg == ut);
      if (ut) m_tg[li] = un;
      if (mis) m_ep = m_ep + 2'd1;
    end
  endtask

  // realistic update: prediction fields as the block would have produced them
  task automatic real_upd(input logic [31:0] fpc, input logic [31:0] upc,
                          input logic ut, input logic [31:0] un);
    logic t, g, l, c;
    logic [31:0] n;
    model_pred(upc, t, n, g, l, c);
    step(fpc, 1'b1, upc, m_ep, ut, un, t, n, g, l, m_ghr);
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        failures++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240607);
    rst_n = 1'b0;
    f_pc = '0; u_valid = 0; u_pc = '0; u_epoch = '0; u_taken = 0; u_next_pc = '0;
    u_pred_taken = 0; u_pred_next = '0; u_pred_glob = 0; u_pred_loc = 0; u_ghist = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state seen from several fetch addresses
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      f_pc = 32'h0000_2000 + 32'(k * 36); u_valid = 0;
      #1;
      chk("R1 taken after reset", 32'(p_taken), 32'd0);
      chk("R1 next pc after reset", p_next_pc, f_pc + 32'd4);
      chk("R1 chooser after reset", 32'(p_use_glob), 32'd0);
      chk("R1 epoch after reset", 32'(f_epoch), 32'd0);
      chk("R1 ghist after reset", 32'(p_ghist), 32'd0);
    end

    // R5: long taken run then long not-taken run on one branch (saturation both ends)
    for (int k = 0; k < 10; k++) real_upd(32'h0000_1040, 32'h0000_1040, 1'b1, 32'h0000_1200);
    step(32'h0000_1040, 1'b0, '0, m_ep, 0, '0, 0, '0, 0, 0, '0);
    chk("R6 trained target used", p_next_pc, 32'h0000_1200);
    for (int k = 0; k < 10; k++) real_upd(32'h0000_1040, 32'h0000_1040, 1'b0, 32'h0000_1044);
    step(32'h0000_1040, 1'b0, '0, m_ep, 0, '0, 0, '0, 0, 0, '0);
    chk("R5 not-taken after saturation low", 32'(p_taken), 32'd0);

    // R7: direction right, target wrong on a taken branch
    for (int k = 0; k < 8; k++) real_upd(32'h0000_1080, 32'h0000_1080, 1'b1, 32'h0000_1300);
    real_upd(32'h0000_1080, 32'h0000_1080, 1'b1, 32'h0000_1340);
    step(32'h0000_1080, 1'b0, '0, m_ep, 0, '0, 0, '0, 0, 0, '0);
    chk("R6 target replaced", p_next_pc, 32'h0000_1340);

    // R8: stale update with every other field active, then observe the ports
    begin
      logic [1:0] ep_before;
      logic [5:0] gh_before;
      ep_before = m_ep; gh_before = m_ghr;
      step(32'h0000_1080, 1'b1, 32'h0000_1080, m_ep + 2'd1, 1'b0, 32'h0000_1084,
           1'b1, 32'h0000_1340, 1'b1, 1'b0, m_ghr);
      step(32'h0000_1080, 1'b0, '0, m_ep, 0, '0, 0, '0, 0, 0, '0);
      chk("R8 epoch unchanged by stale", 32'(f_epoch), 32'(ep_before));
      chk("R8 ghist unchanged by stale", 32'(p_ghist), 32'(gh_before));
      chk("R8 target unchanged by stale", p_next_pc, 32'h0000_1340);
    end

    // R9: idle cycles with garbage on the update fields
    for (int k = 0; k < 6; k++)
      step(32'h0000_1080, 1'b0, 32'h0000_1080, m_ep, 1'b0, 32'h0,
           1'b1, 32'hdead_beef, 1'b1, 1'b0, 6'h2a);
    chk("R9 target kept while idle", p_next_pc, 32'h0000_1340);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] fpc, upc, un, upn;
      logic ut, uv, upt, upg, upl;
      logic [1:0] uep;
      logic [5:0] ugh;
      fpc = 32'h0000_1000 + 32'(($urandom % 128) * 4);
      upc = 32'h0000_1000 + 32'(($urandom % 128) * 4);
      ut  = upc[3] ^ (($urandom % 6) == 0);
      un  = ut ? (upc + 32'h100 + (($urandom % 8) == 0 ? 32'd4 : 32'd0)) : upc + 32'd4;
      uv  = ($urandom % 10) != 0;
      uep = (($urandom % 8) == 0) ? m_ep + 2'(1 + $urandom % 3) : m_ep;
      if ($urandom % 2 == 0 && uv && uep == m_ep) begin
        real_upd(fpc, upc, ut, un);
      end else begin
        upt = 1'($urandom); upg = 1'($urandom); upl = 1'($urandom);
        upn = ($urandom % 2 == 0) ? un : upc + 32'h100;
        ugh = 6'($urandom);
        step(fpc, uv, upc, uep, ut, un, upt, upn, upg, upl, ugh);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule